// File: doc/BRIEF.md
# Dot inversion polarity selector

This block sits in the digital front of a column driver that uses dot inversion. For every output position it decides whether the analog stage should draw on the high (positive) or the low (negative) reference set. It also flags the positions that carry no output in the reduced-width modes. Neighbouring positions always take opposite polarities. The whole pattern flips when the exclusive-or of two inversion inputs changes, but only once that value has been captured while the load strobe is high.

The block also conditions the two 6-bit pixel code ports. Each port has its own inversion control. On every clock the code is registered, and it is complemented on the same edge if that port's control is high. The analog selection of reference voltages is handled downstream. The block produces only the polarity decision, the active mask and the conditioned codes.

Top module: `dot_polarity_sel`

## Requirements
- R1: After reset, every valid position shows the base pattern (position index 0 negative, index 1 positive, and so on, alternating). Both code outputs read 0.
- R2: On a rising clock edge where `ld_i` is high, the block captures a flip bit equal to `rev_i ^ rev2_i`. From the following cycle, the polarity of every valid position is its base value XOR that flip bit.
- R3: While `ld_i` is low, changes on `rev_i` and `rev2_i` leave `pol_o` unchanged.
- R4: The polarity bit is 1 for the high (positive) reference set and 0 for the low set. A valid position p (0-based) shows `(p mod 2) XOR flip`, so adjacent valid positions always differ.
- R5: Positions are grouped three per group, and group g covers indices 3(g-1) to 3(g-1)+2. The mode is `{reduced_i, one_port_i}`. The invalid groups are:
  - 00: none
  - 01: group 54
  - 10: groups 55 to 58
  - 11: groups 54 to 58

  An invalid position shows `act_o` = 0 and `pol_o` = 0. The active mask follows the mode inputs within the same cycle.
- R6: The number of active positions is 324, 321, 312 and 309 for modes 00, 01, 10 and 11 respectively.
- R7: `code_a_o` takes `din_a_i` at each rising edge, complemented bitwise when `inv_a_i` is high at that edge.
- R8: `code_b_o` behaves the same way from `din_b_i` and `inv_b_i`. It is independent of the port A control.
- R9: With `rev2_i` tied low, the captured flip bit equals `rev_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rev_i | input | 1 | Primary polarity inversion control |
| rev2_i | input | 1 | Secondary polarity inversion control (tie low if unused) |
| ld_i | input | 1 | Load strobe; polarity is captured while high |
| reduced_i | input | 1 | Reduced output count select |
| one_port_i | input | 1 | Single-port data mode select |
| inv_a_i | input | 1 | Port A code inversion control |
| inv_b_i | input | 1 | Port B code inversion control |
| din_a_i | input | 6 | Port A pixel code |
| din_b_i | input | 6 | Port B pixel code |
| code_a_o | output | 6 | Registered, optionally complemented port A code |
| code_b_o | output | 6 | Registered, optionally complemented port B code |
| pol_o | output | 324 | Per-position polarity (1 = positive set) |
| act_o | output | 324 | Per-position active flag |

## Verification
A polarity capture under the load strobe and a port inversion change can land on the same clock edge. A mode change can arrive in that same cycle too. The bench drives random combinations of the strobe, both inversion controls, both port controls and the mode pins on shared edges. Its behavioural model predicts the flip bit, both codes and the full masks on every cycle. The cycle where both the polarity and the codes change is judged by comparing all outputs together at the next falling edge.

// File: rtl/dot_polarity_sel.sv
module dot_polarity_sel #(
  parameter int NUM_GRP    = 108,
  parameter int CW         = 6,
  parameter int NARROW_GRP = 54,
  parameter int WIDE_LO    = 55,
  parameter int WIDE_HI    = 58,
  localparam int NP        = 3 * NUM_GRP,
  localparam int GW        = $clog2(NUM_GRP + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rev_i,
  input  logic          rev2_i,
  input  logic          ld_i,
  input  logic          reduced_i,
  input  logic          one_port_i,
  input  logic          inv_a_i,
  input  logic          inv_b_i,
  input  logic [CW-1:0] din_a_i,
  input  logic [CW-1:0] din_b_i,
  output logic [CW-1:0] code_a_o,
  output logic [CW-1:0] code_b_o,
  output logic [NP-1:0] pol_o,
  output logic [NP-1:0] act_o
);

  logic          flip_q;
  logic [GW-1:0] gap_lo, gap_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flip_q   <= 1'b0;
      code_a_o <= '0;
      code_b_o <= '0;
    end else begin
      if (ld_i) flip_q <= rev_i ^ rev2_i;
      code_a_o <= din_a_i ^ {CW{inv_a_i}};
      code_b_o <= din_b_i ^ {CW{inv_b_i}};
    end
  end

  always_comb begin
    unique case ({reduced_i, one_port_i})
      2'b01:   begin gap_lo = GW'(NARROW_GRP); gap_hi = GW'(NARROW_GRP); end
      2'b10:   begin gap_lo = GW'(WIDE_LO);    gap_hi = GW'(WIDE_HI);    end
      2'b11:   begin gap_lo = GW'(NARROW_GRP); gap_hi = GW'(WIDE_HI);    end
      default: begin gap_lo = GW'(1);          gap_hi = GW'(0);          end
    endcase
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic live;
    assign live = !((GW'(g + 1) >= gap_lo) && (GW'(g + 1) <= gap_hi));
    for (genvar c = 0; c < 3; c++) begin : g_pos
      localparam int P = 3 * g + c;
      assign act_o[P] = live;
      assign pol_o[P] = live & (flip_q ^ ((P % 2) == 1));
    end
  end

endmodule

// File: rtl/dot_polarity_sel_chk.sv
module dot_polarity_sel_chk #(
  parameter int NUM_GRP    = 108,
  parameter int CW         = 6,
  parameter int NARROW_GRP = 54,
  parameter int WIDE_LO    = 55,
  parameter int WIDE_HI    = 58,
  localparam int NP        = 3 * NUM_GRP
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rev_i,
  input logic          rev2_i,
  input logic          ld_i,
  input logic          reduced_i,
  input logic          one_port_i,
  input logic          inv_a_i,
  input logic          inv_b_i,
  input logic [CW-1:0] din_a_i,
  input logic [CW-1:0] din_b_i,
  input logic [CW-1:0] code_a_o,
  input logic [CW-1:0] code_b_o,
  input logic [NP-1:0] pol_o,
  input logic [NP-1:0] act_o
);
  int exp_cnt;
  always_comb begin
    case ({reduced_i, one_port_i})
      2'b01:   exp_cnt = NP - 3;
      2'b10:   exp_cnt = NP - 3 * (WIDE_HI - WIDE_LO + 1);
      2'b11:   exp_cnt = NP - 3 * (WIDE_HI - NARROW_GRP + 1);
      default: exp_cnt = NP;
    endcase
  end

  // R2
  load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_i |=> pol_o[0] == $past(rev_i ^ rev2_i));
  // R3
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_i |=> $stable(pol_o[0]));
  // R4
  neighbour_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pol_o[0] != pol_o[1]);
  // R5
  dead_is_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pol_o & ~act_o) == '0);
  // R6
  active_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(act_o) == exp_cnt);
  // R7
  code_a_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inv_a_i |=> code_a_o == $past(din_a_i));
  // R8
  code_b_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_b_i |=> code_b_o == ~$past(din_b_i));
endmodule

bind dot_polarity_sel dot_polarity_sel_chk #(
  .NUM_GRP(NUM_GRP), .CW(CW), .NARROW_GRP(NARROW_GRP),
  .WIDE_LO(WIDE_LO), .WIDE_HI(WIDE_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rev_i(rev_i), .rev2_i(rev2_i), .ld_i(ld_i),
  .reduced_i(reduced_i), .one_port_i(one_port_i), .inv_a_i(inv_a_i),
  .inv_b_i(inv_b_i), .din_a_i(din_a_i), .din_b_i(din_b_i),
  .code_a_o(code_a_o), .code_b_o(code_b_o), .pol_o(pol_o), .act_o(act_o)
);

// File: tb/dot_polarity_sel_bench.sv
module dot_polarity_sel_bench;
  localparam int NP = 324;

  logic clk = 1'b0, rst_n = 1'b0;
  logic rev_i = 0, rev2_i = 0, ld_i = 0, reduced_i = 0, one_port_i = 0;
  logic inv_a_i = 0, inv_b_i = 0;
  logic [5:0] din_a_i = 0, din_b_i = 0, code_a_o, code_b_o;
  logic [NP-1:0] pol_o, act_o;

  int checks = 0, errors = 0;
  bit done = 0;
  logic flip_m = 0;
  logic [5:0] ca_m = 0, cb_m = 0;

  always #10 clk = ~clk;

  dot_polarity_sel u_dot_polarity_sel (.*);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin flip_m <= 0; ca_m <= 0; cb_m <= 0; end
    else begin
      if (ld_i) flip_m <= rev_i ^ rev2_i;
      ca_m <= inv_a_i ? ~din_a_i : din_a_i;
      cb_m <= inv_b_i ? ~din_b_i : din_b_i;
    end
  end

  function automatic bit dead(int p, logic red, logic one);
    int g = p / 3 + 1;
    case ({red, one})
      2'b01:   return g == 54;
      2'b10:   return g >= 55 && g <= 58;
      2'b11:   return g >= 54 && g <= 58;
      default: return 0;
    endcase
  endfunction

  function automatic logic [NP-1:0] exp_act(logic red, logic one);
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = !dead(p, red, one);
    return v;
  endfunction

  function automatic logic [NP-1:0] exp_pol(logic f, logic red, logic one);
    logic [NP-1:0] v;
    for (int p = 0; p < NP; p++) v[p] = dead(p, red, one) ? 1'b0 : ((p % 2 == 1) ^ f);
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [NP-1:0] act, logic [NP-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk(pol_o === exp_pol(flip_m, reduced_i, one_port_i), "R2 R4 pol", pol_o,
        exp_pol(flip_m, reduced_i, one_port_i));
    chk(act_o === exp_act(reduced_i, one_port_i), "R5 act", act_o, exp_act(reduced_i, one_port_i));
    chk(code_a_o === ca_m, "R7 code_a", NP'(code_a_o), NP'(ca_m));
    chk(code_b_o === cb_m, "R8 code_b", NP'(code_b_o), NP'(cb_m));
  end

  task automatic step();
    @(posedge clk); #3;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #3 rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(pol_o === exp_pol(0, 0, 0) && code_a_o == 0 && code_b_o == 0, "R1 reset",
            pol_o, exp_pol(0, 0, 0));
        // R9: rev2 low, rev high captured
        step(); rev_i = 1; ld_i = 1; step(); ld_i = 0;
        @(negedge clk);
        chk(pol_o[0] === 1'b1, "R9 rev alone", NP'(pol_o[0]), NP'(1));
        // R3: rev toggles with ld low
        for (int i = 0; i < 6; i++) begin step(); rev_i = ~rev_i; rev2_i = i[1]; end
        @(negedge clk);
        chk(pol_o[0] === 1'b1, "R3 hold", NP'(pol_o[0]), NP'(1));
        // R6 counts per mode
        for (int m = 0; m < 4; m++) begin
          step(); {reduced_i, one_port_i} = 2'(m);
          @(negedge clk);
          chk($countones(act_o) == (m == 0 ? 324 : m == 1 ? 321 : m == 2 ? 312 : 309),
              "R6 count", NP'($countones(act_o)), NP'(m));
        end
        // R2 equal pins give base pattern
        step(); rev_i = 1; rev2_i = 1; ld_i = 1; step(); ld_i = 0;
        @(negedge clk);
        chk(pol_o[0] === 1'b0, "R2 equal pins", NP'(pol_o[0]), NP'(0));
        // R7 R8 fixed inversion pattern
        step(); din_a_i = 6'h15; din_b_i = 6'h15; inv_a_i = 1; inv_b_i = 0;
        step();
        @(negedge clk);
        chk(code_a_o == 6'h2A && code_b_o == 6'h15, "R7 R8 independent",
            NP'({code_a_o, code_b_o}), NP'({6'h2A, 6'h15}));
        // mixed random traffic: strobe, inversion and mode on shared edges
        for (int i = 0; i < 600; i++) begin
          step();
          rev_i = $urandom; rev2_i = $urandom; ld_i = ($urandom % 3) == 0;
          inv_a_i = $urandom; inv_b_i = $urandom;
          din_a_i = 6'($urandom); din_b_i = 6'($urandom);
          if ($urandom % 8 == 0) {reduced_i, one_port_i} = 2'($urandom);
        end
        step(); @(negedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule